// File: doc/BRIEF.md
# I2C Interrupt Status and Mask Unit

This block gathers the event pulses that an I2C controller core raises and keeps them in a sticky interrupt status register. Software clears that register by writing ones to it. Each source also has a bit in an interrupt mask. The mask cannot be written directly. Software changes it through two write-only registers: one that unmasks sources and one that masks them. The unit drives a single interrupt line, which is high while any pending source is unmasked.

The unit also shows four live controller conditions in a read-only status word. These are receive data valid, transmit data valid, receive overflow and bus active. Register access uses a 32-bit write port and a combinational read port, both addressed by byte offset. The event sources sit at bits 0 to 7 and bit 9. Bit 8 has no source and is held at zero.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, the status register at offset 0x10 reads 0, the mask at offset 0x20 reads 0x2FF, and `irq_o` is low.
- R2: An event pulse on source bit i sets status bit i from the next cycle onward. The bit stays set with no further pulse until it is cleared. The sources are completion 0, data 1, NACK 2, timeout 3, slave ready 4, RX overflow 5, TX overflow 6, RX underflow 7 and arbitration lost 9.
- R3: A write to offset 0x10 clears every status bit written as 1 and leaves bits written as 0 unchanged. Writing 0x2FF clears all pending events.
- R4: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x24 clears the mask bits written as 1, which unmasks those sources. A write to offset 0x28 sets the mask bits written as 1. Bits written as 0 leave the mask unchanged.
- R6: The mask at offset 0x20 is read-only. A write to that offset leaves both the mask and the status unchanged.
- R7: `irq_o` is high exactly when some status bit is set and its mask bit is 0.
- R8: Bit 8 and bits 10 to 31 of the status and mask read as 0. Event pulses and writes aimed at those bits have no effect.
- R9: Offset 0x04 reads the live word: bit 5 RX data valid, bit 6 TX data valid, bit 7 RX overflow, bit 8 bus active. All other bits read as 0.
- R10: Every other offset reads 0, including the write-only offsets 0x24 and 0x28. A write to any other offset changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one per cycle |
| addr | input | 8 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_i | input | 10 | One-cycle event pulses, one per source bit position |
| rx_valid_i | input | 1 | Live: receive data valid |
| tx_valid_i | input | 1 | Live: transmit data valid |
| rx_ovf_i | input | 1 | Live: receive overflow |
| bus_busy_i | input | 1 | Live: bus active |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound assertions check several rules on every cycle. An event pulse always leaves its bit set, even when a clear arrives in the same cycle. A clearing write with no event empties the written bits. Enable and disable writes move exactly the written mask bits, and the mask stays put when neither is written. The unused positions stay zero, and the interrupt line is never raised while nothing is pending. Some behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These cover the reset values, the read mux for each offset (the live word included), the fact that writes to the mask address and to unrelated offsets are ignored, and the interplay of masking and pending events on `irq_o` across long mixed sequences.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_ADDR_W = 8;
   localparam int unsigned DEF_SRC_W  = 10;

   // Source positions; position 8 carries no source
   localparam logic [DEF_SRC_W-1:0] DEF_SRC_MASK = 10'h2FF;

   localparam logic [DEF_ADDR_W-1:0] DEF_OFF_LIVE = 8'h04;
   localparam logic [DEF_ADDR_W-1:0] DEF_OFF_PEND = 8'h10;
   localparam logic [DEF_ADDR_W-1:0] DEF_OFF_MASK = 8'h20;
   localparam logic [DEF_ADDR_W-1:0] DEF_OFF_UNMK = 8'h24;
   localparam logic [DEF_ADDR_W-1:0] DEF_OFF_MSKS = 8'h28;

   localparam int unsigned DEF_LIVE_LSB = 5;
   localparam int unsigned LIVE_W       = 4;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_LIVE = 2'd1,
      RD_PEND = 2'd2,
      RD_MASK = 2'd3
   } rd_sel_e;

   typedef struct packed {
      logic    pend_clr;
      logic    mask_clr;
      logic    mask_set;
      rd_sel_e rd_sel;
   } dec_t;

endpackage

// File: rtl/i2c_irq_addr_dec.sv
module i2c_irq_addr_dec
   import i2c_irq_pkg::*;
#(
   parameter int unsigned     ADDR_W   = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] OFF_LIVE = DEF_OFF_LIVE,
   parameter logic [ADDR_W-1:0] OFF_PEND = DEF_OFF_PEND,
   parameter logic [ADDR_W-1:0] OFF_MASK = DEF_OFF_MASK,
   parameter logic [ADDR_W-1:0] OFF_UNMK = DEF_OFF_UNMK,
   parameter logic [ADDR_W-1:0] OFF_MSKS = DEF_OFF_MSKS
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   always_comb begin
      dec.pend_clr = wr_en && (addr == OFF_PEND);
      dec.mask_clr = wr_en && (addr == OFF_UNMK);
      dec.mask_set = wr_en && (addr == OFF_MSKS);
      if (addr == OFF_LIVE)      dec.rd_sel = RD_LIVE;
      else if (addr == OFF_PEND) dec.rd_sel = RD_PEND;
      else if (addr == OFF_MASK) dec.rd_sel = RD_MASK;
      else                       dec.rd_sel = RD_NONE;
   end

endmodule

// File: rtl/i2c_irq_status_bank.sv
module i2c_irq_status_bank
   import i2c_irq_pkg::*;
#(
   parameter int unsigned          SRC_W    = DEF_SRC_W,
   parameter logic [SRC_W-1:0]     SRC_MASK = DEF_SRC_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] evt,
   input  logic             clr_we,
   input  logic [SRC_W-1:0] clr_bits,
   output logic [SRC_W-1:0] pend_q
);

   for (genvar i = 0; i < SRC_W; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q[i] <= 1'b0;
            else if (evt[i])
               pend_q[i] <= 1'b1;          // a new event beats a clear
            else if (clr_we && clr_bits[i])
               pend_q[i] <= 1'b0;
         end
      end else begin : g_tie
         assign pend_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/i2c_irq_mask_bank.sv
module i2c_irq_mask_bank
   import i2c_irq_pkg::*;
#(
   parameter int unsigned      SRC_W    = DEF_SRC_W,
   parameter logic [SRC_W-1:0] SRC_MASK = DEF_SRC_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [SRC_W-1:0] wbits,
   output logic [SRC_W-1:0] mask_q
);

   for (genvar i = 0; i < SRC_W; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_q[i] <= 1'b1;
            else if (set_we && wbits[i])
               mask_q[i] <= 1'b1;
            else if (clr_we && wbits[i])
               mask_q[i] <= 1'b0;
         end
      end else begin : g_tie
         assign mask_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
   import i2c_irq_pkg::*;
#(
   parameter int unsigned        DATA_W   = DEF_DATA_W,
   parameter int unsigned        ADDR_W   = DEF_ADDR_W,
   parameter int unsigned        SRC_W    = DEF_SRC_W,
   parameter logic [SRC_W-1:0]   SRC_MASK = DEF_SRC_MASK,
   parameter int unsigned        LIVE_LSB = DEF_LIVE_LSB,
   parameter logic [ADDR_W-1:0]  OFF_LIVE = DEF_OFF_LIVE,
   parameter logic [ADDR_W-1:0]  OFF_PEND = DEF_OFF_PEND,
   parameter logic [ADDR_W-1:0]  OFF_MASK = DEF_OFF_MASK,
   parameter logic [ADDR_W-1:0]  OFF_UNMK = DEF_OFF_UNMK,
   parameter logic [ADDR_W-1:0]  OFF_MSKS = DEF_OFF_MSKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [SRC_W-1:0]  evt_i,
   input  logic              rx_valid_i,
   input  logic              tx_valid_i,
   input  logic              rx_ovf_i,
   input  logic              bus_busy_i,
   output logic              irq_o
);

   localparam int unsigned PAD_W = DATA_W - SRC_W;
   localparam logic [DATA_W-1:0] SRC_WIDE = {{PAD_W{1'b0}}, SRC_MASK};

   if (SRC_W > DATA_W) begin : g_chk_width
      $error("source vector wider than the data word");
   end
   if (LIVE_LSB + LIVE_W > DATA_W) begin : g_chk_live
      $error("live status field does not fit in the data word");
   end
   if (SRC_MASK == '0) begin : g_chk_src
      $error("no interrupt source enabled");
   end

   dec_t             dec;
   logic [SRC_W-1:0] wbits;
   logic [SRC_W-1:0] evt_v;
   logic [SRC_W-1:0] pend_q;
   logic [SRC_W-1:0] mask_q;
   logic [DATA_W-1:0] live_w;

   assign wbits = SRC_W'(wdata & SRC_WIDE);
   assign evt_v = evt_i & SRC_MASK;

   i2c_irq_addr_dec #(
      .ADDR_W  (ADDR_W),
      .OFF_LIVE(OFF_LIVE),
      .OFF_PEND(OFF_PEND),
      .OFF_MASK(OFF_MASK),
      .OFF_UNMK(OFF_UNMK),
      .OFF_MSKS(OFF_MSKS)
   ) u_dec (
      .wr_en(wr_en),
      .addr (addr),
      .dec  (dec)
   );

   i2c_irq_status_bank #(
      .SRC_W   (SRC_W),
      .SRC_MASK(SRC_MASK)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_v),
      .clr_we  (dec.pend_clr),
      .clr_bits(wbits),
      .pend_q  (pend_q)
   );

   i2c_irq_mask_bank #(
      .SRC_W   (SRC_W),
      .SRC_MASK(SRC_MASK)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_we(dec.mask_set),
      .clr_we(dec.mask_clr),
      .wbits (wbits),
      .mask_q(mask_q)
   );

   always_comb begin
      live_w = '0;
      live_w[LIVE_LSB +: LIVE_W] = {bus_busy_i, rx_ovf_i, tx_valid_i, rx_valid_i};
   end

   always_comb begin
      unique case (dec.rd_sel)
         RD_LIVE: rdata = live_w;
         RD_PEND: rdata = {{PAD_W{1'b0}}, pend_q};
         RD_MASK: rdata = {{PAD_W{1'b0}}, mask_q};
         default: rdata = '0;
      endcase
   end

   assign irq_o = |(pend_q & ~mask_q);

endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
   import i2c_irq_pkg::*;
#(
   parameter int unsigned       DATA_W   = DEF_DATA_W,
   parameter int unsigned       ADDR_W   = DEF_ADDR_W,
   parameter int unsigned       SRC_W    = DEF_SRC_W,
   parameter logic [SRC_W-1:0]  SRC_MASK = DEF_SRC_MASK,
   parameter logic [ADDR_W-1:0] OFF_PEND = DEF_OFF_PEND,
   parameter logic [ADDR_W-1:0] OFF_UNMK = DEF_OFF_UNMK,
   parameter logic [ADDR_W-1:0] OFF_MSKS = DEF_OFF_MSKS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [SRC_W-1:0]  evt_i,
   input logic [SRC_W-1:0]  pend,
   input logic [SRC_W-1:0]  mask,
   input logic              irq_o
);

   logic [SRC_W-1:0] wd;
   logic [SRC_W-1:0] ev;
   logic             mask_wr;
   assign wd      = SRC_W'(wdata) & SRC_MASK;
   assign ev      = evt_i & SRC_MASK;
   assign mask_wr = wr_en && (addr == OFF_UNMK || addr == OFF_MSKS);

   p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == '0 && !(wr_en && addr == OFF_PEND)) |=> $stable(pend));

   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFF_PEND && ev == '0) |=> ((pend & $past(wd)) == '0));

   p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFF_UNMK) |=> ((mask & $past(wd)) == '0));

   p_domask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFF_MSKS) |=> ((mask & $past(wd)) == $past(wd)));

   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask));

   p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~SRC_MASK) == '0) && ((mask & ~SRC_MASK) == '0));

   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq_o);

endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SRC_W   (SRC_W),
   .SRC_MASK(SRC_MASK),
   .OFF_PEND(OFF_PEND),
   .OFF_UNMK(OFF_UNMK),
   .OFF_MSKS(OFF_MSKS)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .wr_en(wr_en),
   .addr (addr),
   .wdata(wdata),
   .evt_i(evt_i),
   .pend (pend_q),
   .mask (mask_q),
   .irq_o(irq_o)
);

// File: tb/sim_i2c_irq_unit.sv
module sim_i2c_irq_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [9:0]  evt_i = '0;
   logic        rx_valid_i = 1'b0;
   logic        tx_valid_i = 1'b0;
   logic        rx_ovf_i = 1'b0;
   logic        bus_busy_i = 1'b0;
   logic        irq_o;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // behavioural reference state
   int unsigned m_pend;
   int unsigned m_mask;

   always #10 clk = ~clk;

   i2c_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt_i(evt_i), .rx_valid_i(rx_valid_i),
      .tx_valid_i(tx_valid_i), .rx_ovf_i(rx_ovf_i), .bus_busy_i(bus_busy_i),
      .irq_o(irq_o)
   );

   function automatic int unsigned exp_read(input logic [7:0] a);
      int unsigned v;
      case (a)
         8'h04: v = (int'(rx_valid_i) << 5) | (int'(tx_valid_i) << 6) |
                    (int'(rx_ovf_i) << 7) | (int'(bus_busy_i) << 8);
         8'h10: v = m_pend;
         8'h20: v = m_mask;
         default: v = 0;
      endcase
      return v;
   endfunction

   task automatic compare(input string tag);
      int unsigned er;
      bit ei;
      er = exp_read(addr);
      ei = ((m_pend & ~m_mask & 32'h2FF) != 0);
      vectors++;
      if (rdata !== er || irq_o !== ei) begin
         errors++;
         $display("FAIL %s: addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                  tag, addr, rdata, irq_o, er, ei);
      end
   endtask

   // apply one cycle of stimulus, advance the model, check at the falling edge
   task automatic step(input bit we, input logic [7:0] a, input int unsigned wd,
                       input int unsigned ev, input string tag);
      wr_en = we; addr = a; wdata = wd; evt_i = ev[9:0];
      @(posedge clk);
      if (we) begin
         if (a == 8'h10) m_pend = m_pend & ~wd;
         if (a == 8'h24) m_mask = m_mask & ~wd;
         if (a == 8'h28) m_mask = m_mask | wd;
      end
      m_pend = (m_pend | ev) & 32'h2FF;
      m_mask = m_mask & 32'h2FF;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle_read(input logic [7:0] a, input string tag);
      step(1'b0, a, 0, 0, tag);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int unsigned lfsr;
      m_pend = 0;
      m_mask = 32'h2FF;
      @(negedge clk);
      @(negedge clk);
      addr = 8'h20; #1 compare("R1 mask reset");
      addr = 8'h10; #1 compare("R1 status reset");
      rst_n = 1'b1;

      step(0, 8'h10, 0, 10'h001, "R2 completion event sets bit 0");
      idle_read(8'h10, "R2 sticky without further pulse");
      step(0, 8'h10, 0, 10'h3FF, "R8 all pulses, bit 8 ignored");
      step(1, 8'h10, 32'h005, 0, "R3 clear bits 0 and 2");
      step(1, 8'h10, 32'h000, 0, "R3 zeros leave bits");
      step(1, 8'h10, 32'h200, 10'h200, "R4 set wins over clear");
      step(1, 8'h20, 32'h0, 0, "R6 write to mask ignored");
      idle_read(8'h20, "R6 mask still all ones");
      idle_read(8'h10, "R6 status unchanged");
      step(1, 8'h24, 32'h002, 0, "R5 unmask data source, R7 irq rises");
      idle_read(8'h20, "R5 mask after unmask");
      step(1, 8'h24, 32'hFFFF_FFFF, 0, "R5 unmask all");
      idle_read(8'h20, "R8 mask upper bits zero");
      step(1, 8'h28, 32'h100, 0, "R8 disable of bit 8 ignored");
      idle_read(8'h20, "R8 mask bit 8 reads zero");
      step(1, 8'h10, 32'hFFFF_FFFF, 0, "R3 clear all, R7 irq falls");
      step(1, 8'h28, 32'h00F, 0, "R5 mask low sources");
      idle_read(8'h20, "R5 mask after disable write");
      step(0, 8'h10, 0, 10'h004, "R7 masked NACK keeps irq low");
      step(0, 8'h10, 0, 10'h200, "R7 unmasked arbitration lost raises irq");
      rx_valid_i = 1'b1; bus_busy_i = 1'b1;
      idle_read(8'h04, "R9 live word rx valid and bus active");
      rx_valid_i = 1'b0; tx_valid_i = 1'b1; rx_ovf_i = 1'b1; bus_busy_i = 1'b0;
      idle_read(8'h04, "R9 live word tx valid and overflow");
      step(1, 8'h00, 32'hFFFF_FFFF, 0, "R10 offset 0x00 reads zero");
      step(1, 8'h14, 32'hFFFF_FFFF, 0, "R10 offset 0x14 reads zero");
      idle_read(8'h28, "R10 disable offset reads zero");
      idle_read(8'h10, "R10 status untouched by other writes");
      idle_read(8'h20, "R10 mask untouched by other writes");

      lfsr = 32'hACE1_2345;
      for (int k = 0; k < 400; k++) begin
         logic [7:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[2:0])
            3'd0: a = 8'h04;
            3'd1, 3'd2: a = 8'h10;
            3'd3: a = 8'h20;
            3'd4: a = 8'h24;
            3'd5: a = 8'h28;
            3'd6: a = 8'h0C;
            default: a = 8'h10;
         endcase
         rx_valid_i = lfsr[20]; tx_valid_i = lfsr[21];
         rx_ovf_i = lfsr[22]; bus_busy_i = lfsr[23];
         step(lfsr[3], a, {lfsr[15:4], lfsr[31:12]},
              (lfsr[27:24] == 4'd0) ? lfsr[9:0] : 0,
              "R2 R3 R4 R5 R7 mixed sequence");
      end
      step(0, 8'h10, 0, 0, "R2 final idle");

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule